// File: doc/BRIEF.md
# Periodic Refresh Scheduler

This block keeps every row of an SDRAM refreshed within its retention window. A free-running timer counts system clocks. Each time an average refresh interval has passed, the block adds one refresh to a count of refreshes owed. While anything is owed, it asks the command arbiter for the command bus. When the arbiter grants the bus, the block issues an auto refresh, but only if no bank is open. If a bank is open, it first issues a precharge-all and tries the refresh again on a later grant.

A low-power input puts the device into self refresh. The block drives the refresh command pattern with the clock-enable line dropped in the same cycle, and it holds clock-enable low for as long as the input stays high. When the input falls, the block raises clock-enable over a no-operation command. It then waits out the exit recovery time and restarts the interval timer from zero. The interval length comes from the clock frequency, the retention window and the number of refreshes per window, all given as parameters.

Top module: `refresh_sched`

## Requirements
- R1: The owed count rises by one every INTERVAL = floor(CLK_KHZ*WINDOW_MS/ROWS) clocks. After reset, the first rise happens on the INTERVAL-th rising edge.
- R2: `ref_req` is high exactly when the scheduler is idle (not waiting and not in self refresh) and either the owed count is non-zero or `lp_req` is high.
- R3: The owed count saturates at MAX_OWED (8). Further due intervals are dropped.
- R4: `ref_urgent` is high exactly when more than URGENT_OVER (4) refreshes are owed.
- R5: A grant while `ref_req` is high and `bank_open` is all zero gives, one clock later, auto refresh on the pins: cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0, cke=1. The owed count drops by one in the same clock.
- R6: A grant while `ref_req` is high and any `bank_open` bit is set gives, one clock later, precharge-all on the pins: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. The owed count does not change.
- R7: After a precharge-all, an auto refresh or a self refresh exit, `ref_req` stays low for TRP_CYC, TRFC_CYC or TXSR_CYC clocks respectively.
- R8: A grant while `ref_req` is low is ignored. The pins keep showing the no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1) with cke=1.
- R9: A grant while `lp_req` is high and all banks are closed drives the refresh pattern with cke=0 in the same clock. This is self refresh entry, and it takes priority over auto refresh. The owed count is cleared. While `lp_req` stays high, cke stays low, the owed count stays zero and `ref_req` stays low.
- R10: When `lp_req` falls during self refresh, cke rises one clock later with the no-operation command on the pins. The interval timer restarts, so the next refresh becomes owed INTERVAL clocks after that exit edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | NBANK | One bit per bank that currently has an open row |
| lp_req | input | 1 | Request to enter and remain in self refresh |
| grant | input | 1 | Arbiter grants the command bus to this block |
| ref_req | output | 1 | Request for the command bus |
| ref_urgent | output | 1 | More than URGENT_OVER refreshes are owed |
| owed | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| cke | output | 1 | Clock-enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; set for precharge-all |

## Verification
Every command and clock-enable change appears one clock after the grant or `lp_req` edge that caused it. The bench raises inputs on a falling edge and samples on the next falling edge, so each scoreboard item is compared in exactly that cycle. Owed-count changes land on every INTERVAL-th rising edge, counted from reset release or from the self refresh exit edge. The bench counts edges itself and reads the count one cycle before and on the due edge. Each wait window is checked on its last low cycle and on the first cycle `ref_req` can return. Grants are placed away from interval boundaries so that each decrement is seen on its own.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_KHZ     = 250000,
  parameter int WINDOW_MS   = 64,
  parameter int ROWS        = 4096,
  parameter int MAX_OWED    = 8,
  parameter int URGENT_OVER = 4,
  parameter int NBANK       = 4,
  parameter int TRP_CYC     = 3,
  parameter int TRFC_CYC    = 16,
  parameter int TXSR_CYC    = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NBANK-1:0]                bank_open,
  input  logic                            lp_req,
  input  logic                            grant,
  output logic                            ref_req,
  output logic                            ref_urgent,
  output logic [$clog2(MAX_OWED+1)-1:0]   owed,
  output logic                            cke,
  output logic                            cs_n,
  output logic                            ras_n,
  output logic                            cas_n,
  output logic                            we_n,
  output logic                            a10
);

  localparam int INTERVAL = CLK_KHZ * WINDOW_MS / ROWS;
  localparam int TW       = $clog2(INTERVAL + 1);
  localparam int OW       = $clog2(MAX_OWED + 1);
  localparam int WMAX     = (TRP_CYC > TRFC_CYC) ?
                            ((TRP_CYC > TXSR_CYC) ? TRP_CYC : TXSR_CYC) :
                            ((TRFC_CYC > TXSR_CYC) ? TRFC_CYC : TXSR_CYC);
  localparam int WW       = $clog2(WMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SELF} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [WW-1:0] wcnt;

  wire due    = (st != S_SELF) && (tmr == TW'(INTERVAL - 1));
  wire busy   = |bank_open;
  wire issue  = ref_req && grant;
  wire do_pre = issue && busy;
  wire do_sre = issue && !busy && lp_req;
  wire do_ref = issue && !busy && !lp_req;
  wire sx     = (st == S_SELF) && !lp_req;
  wire at_max = (owed == OW'(MAX_OWED));

  assign ref_req    = (st == S_IDLE) && ((owed != '0) || lp_req);
  assign ref_urgent = owed > OW'(URGENT_OVER);

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_SELF || due) tmr <= '0;
    else                               tmr <= tmr + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_sre || st == S_SELF) owed <= '0;
    else if (do_ref && !(due && !at_max))  owed <= owed - OW'(1);
    else if (!do_ref && due && !at_max)    owed <= owed + OW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (do_pre) begin st <= S_WAIT; wcnt <= WW'(TRP_CYC - 1);  end
          if (do_ref) begin st <= S_WAIT; wcnt <= WW'(TRFC_CYC - 1); end
          if (do_sre) st <= S_SELF;
        end
        S_WAIT: begin
          if (wcnt == '0) st <= S_IDLE;
          else            wcnt <= wcnt - WW'(1);
        end
        S_SELF: if (sx) begin st <= S_WAIT; wcnt <= WW'(TXSR_CYC - 1); end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke <= 1'b1;
      {cs_n, ras_n, cas_n, we_n, a10} <= 5'b01110;
    end else begin
      {cs_n, ras_n, cas_n, we_n, a10} <= 5'b01110;
      if (do_ref || do_sre) {cs_n, ras_n, cas_n, we_n, a10} <= 5'b00010;
      if (do_pre)           {cs_n, ras_n, cas_n, we_n, a10} <= 5'b00101;
      if (do_sre)           cke <= 1'b0;
      else if (sx)          cke <= 1'b1;
    end
  end

  a_r3_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));

  a_r5_ref_banks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && we_n && cke) |-> ($past(bank_open) == '0));

  a_r6_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> a10);

  a_r8_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_n && cas_n && we_n) |-> $past(grant));

  a_r9_cke_fall_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  a_r10_cke_rise_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (ras_n && cas_n && we_n));

  a_r2_no_req_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> cke);

endmodule

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  localparam int CLK_KHZ = 2000;
  localparam int IV      = CLK_KHZ * 64 / 4096;
  localparam int TRP     = 2;
  localparam int TRFC    = 6;
  localparam int TXSR    = 8;

  localparam logic [5:0] C_REF = 6'b000101;
  localparam logic [5:0] C_PRE = 6'b001011;
  localparam logic [5:0] C_SRE = 6'b000100;
  localparam logic [5:0] C_SRX = 6'b011101;

  logic clk = 0, rst_n = 0, lp_req = 0, grant = 0;
  logic [3:0] bank_open = '0;
  logic ref_req, ref_urgent, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [3:0] owed;
  int ntests = 0, nfail = 0, edges = 0;
  logic [5:0] expq[$];
  logic prev_cke = 1'b1;

  refresh_sched #(.CLK_KHZ(CLK_KHZ), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TXSR_CYC(TXSR)) dut (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .lp_req(lp_req), .grant(grant),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .owed(owed), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10));

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", rq, act, exp, edges);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] obs;
      obs = {cs_n, ras_n, cas_n, we_n, a10, cke};
      if (!(ras_n && cas_n && we_n) || cke != prev_cke) begin
        if (expq.size() == 0) chk(0, "R8 unexpected command", int'(obs), 0);
        else begin
          logic [5:0] e;
          e = expq.pop_front();
          chk(obs == e, "R5/R6/R9/R10 scoreboard command", int'(obs), int'(e));
        end
      end
      prev_cke = cke;
    end
  end

  task automatic to_edge(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic issue(input logic [5:0] code);
    expq.push_back(code);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", edges, 0);
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk(cke && !cs_n && ras_n && cas_n && we_n, "reset pins NOP R8", int'(cke), 1);
    chk(owed == 0 && !ref_req && !ref_urgent, "reset owed R2", int'(owed), 0);
    rst_n = 1'b1;

    to_edge(IV - 1);
    chk(owed == 0 && !ref_req, "R1 before first interval", int'(owed), 0);
    to_edge(IV);
    chk(owed == 1, "R1 first interval", int'(owed), 1);
    chk(ref_req == 1, "R2 req with owed", int'(ref_req), 1);
    to_edge(4 * IV + 2);
    chk(owed == 4 && !ref_urgent, "R4 urgent low at 4", int'(ref_urgent), 0);
    to_edge(5 * IV + 2);
    chk(owed == 5 && ref_urgent, "R4 urgent high at 5", int'(ref_urgent), 1);
    to_edge(10 * IV + 2);
    chk(owed == 8, "R3 saturate at 8", int'(owed), 8);

    to_edge(10 * IV + 5);
    issue(C_REF);
    v = edges;
    chk(owed == 7, "R5 owed decrement", int'(owed), 7);
    to_edge(v + TRFC - 1);
    chk(!ref_req, "R7 trfc window", int'(ref_req), 0);
    to_edge(v + TRFC);
    chk(ref_req, "R7 trfc end", int'(ref_req), 1);

    bank_open = 4'b0011;
    issue(C_PRE);
    v = edges;
    chk(owed == 7, "R6 owed unchanged by precharge", int'(owed), 7);
    bank_open = '0;
    to_edge(v + TRP - 1);
    chk(!ref_req, "R7 trp window", int'(ref_req), 0);
    to_edge(v + TRP);
    chk(ref_req, "R7 trp end", int'(ref_req), 1);
    issue(C_REF);
    chk(owed == 6, "R5 refresh after precharge", int'(owed), 6);

    for (int i = 0; i < 40 && (owed != 0 || !ref_req); i++) begin
      while (!ref_req) @(negedge clk);
      issue(C_REF);
      if (owed == 0) break;
    end
    while (!ref_req && owed != 0) @(negedge clk);
    repeat (TRFC + 1) @(negedge clk);
    while (owed != 0) begin
      while (!ref_req) @(negedge clk);
      issue(C_REF);
      repeat (TRFC) @(negedge clk);
    end
    chk(!ref_req, "R2 no req when nothing owed", int'(ref_req), 0);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(cke && !cs_n && ras_n && cas_n && we_n, "R8 grant ignored", int'({ras_n, cas_n, we_n}), 7);

    lp_req = 1'b1;
    bank_open = 4'b0100;
    #0;
    chk(ref_req, "R2 req on low power", int'(ref_req), 1);
    issue(C_PRE);
    v = edges;
    bank_open = '0;
    to_edge(v + TRP);
    issue(C_SRE);
    chk(!cke && owed == 0 && !ref_req, "R9 entry", int'(cke), 0);
    repeat (3 * IV) @(negedge clk);
    chk(!cke && owed == 0 && !ref_req, "R9 held in self refresh", int'(owed), 0);

    expq.push_back(C_SRX);
    lp_req = 1'b0;
    @(negedge clk);
    v = edges;
    chk(cke, "R10 cke rises", int'(cke), 1);
    to_edge(v + TXSR - 1);
    chk(!ref_req, "R7 txsr window", int'(ref_req), 0);
    to_edge(v + IV - 1);
    chk(owed == 0, "R10 timer restart before", int'(owed), 0);
    to_edge(v + IV);
    chk(owed == 1 && ref_req, "R10 timer restart due", int'(owed), 1);

    @(negedge clk);
    chk(expq.size() == 0, "scoreboard drained", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule